// File: doc/BRIEF.md
# Link Reset and Codec Detector

This block is a hardware sequencer for an audio codec link controller. A single start pulse makes it take the link out of reset and find out which codec slots are populated. It reaches the controller through a memory-mapped register master port. This port issues word reads and writes, and it returns read data on a separate strobe.

The block first drives the link reset bit low, then drives it high. Each of these steps is a read-modify-write. After each write the block keeps reading the register back, with a programmable wait between reads, until the written bit is seen. If the retry budget runs out first, the step times out. Once the link is out of reset, the block reads the slot presence field and reports it with a done pulse and an error flag. If a step times out, or no slot answers, the block puts the link back into reset before it reports an empty mask with the error flag set.

Top module: `link_reset_detector`

## Requirements
- R1: A one-cycle `start` while idle begins a run. `busy` is high from the cycle after `start` until the cycle in which `done` rises, where it drops. A `start` while busy is ignored. No request is presented while not busy.
- R2: A confirmed write first reads the word at the target address. It then writes back the word read with only the masked bits replaced by the masked value, so every other bit keeps its old value.
- R3: After the write is accepted, the block waits at least `POLL_CYCLES` clock cycles before each readback. A readback succeeds when the masked read data equals the masked value.
- R4: A confirmed write makes at most `RETRIES` readbacks (default 50). If none of them match, the step fails.
- R5: A run first writes 0 to bit 0 of the control word at byte address 0x08, then writes 1 to it. Both are confirmed writes.
- R6: When both reset steps succeed, the block reads the word at address 0x0E. If its bits [3:0] are non-zero, `done` reports them on `codec_mask` with `no_codec` low. Higher bits are ignored.
- R7: If a reset step fails, or bits [3:0] at 0x0E are zero, the block makes a confirmed write of 0 to bit 0 at 0x08. It then raises `done` with `codec_mask` = 0 and `no_codec` = 1.
- R8: A request keeps its address, write flag and write data stable while `req_valid` is high and `req_ready` is low. No new request is presented while a read response is still awaited.
- R9: `done` lasts exactly one cycle. `codec_mask` and `no_codec` keep their values until the next accepted start.
- R10: A synchronous active-high `rst` returns the block to idle with `busy`, `done`, `codec_mask`, `no_codec` and `req_valid` all low. No `done` follows from an aborted run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| codec_mask | output | PRESENCE_W | Populated slot mask, valid from done |
| no_codec | output | 1 | Run failed or found no codec |
| req_valid | output | 1 | Register request valid |
| req_ready | input | 1 | Register request accepted |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | AW | Byte address of the word |
| req_wdata | output | DW | Write data |
| rsp_valid | input | 1 | Read data valid strobe |
| rsp_rdata | input | DW | Read data |

## Verification
The embedded assertions check, on every cycle, the properties that hold cycle by cycle:
- request stability under back-pressure and a single outstanding read;
- the length of the done pulse and how busy ends;
- an empty mask on failure and a non-empty mask on success;
- that the mask is held between runs and the retry counter stays bounded.

Only the bench scenarios can show the rest, because it depends on what the register model returns. This covers the read-modify-write merge preserving foreign bits, the exact write order, the readback count under a lagging or stuck reset bit, the minimum wait before the first readback, and the clean-up write after a timeout or an empty presence field.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
  localparam int CTRL_OFFSET   = 8;
  localparam int STATUS_OFFSET = 14;
  localparam int RESET_BIT     = 0;
  localparam int PRESENCE_W    = 4;

  typedef enum logic [2:0] {
    P_IDLE, P_RD, P_RD_WAIT, P_WR, P_WAIT, P_POLL, P_POLL_WAIT
  } poll_st_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ENTER, S_EXIT, S_STS, S_STS_WAIT, S_CLEAN
  } seq_st_e;
endpackage

// File: rtl/lrd_interval_timer.sv
module lrd_interval_timer #(
  parameter int POLL_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic expired
);
  localparam int CW = $clog2(POLL_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      run     <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (kick) begin
        cnt <= CW'(POLL_CYCLES);
        run <= 1'b1;
      end else if (run) begin
        if (cnt == CW'(1)) begin
          expired <= 1'b1;
          run     <= 1'b0;
        end
        cnt <= cnt - CW'(1);
      end
    end
  end

  AST_EXPIRE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    expired |-> $past(run)); // R3
endmodule

// File: rtl/lrd_rmw_poller.sv
module lrd_rmw_poller
  import lrd_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int POLL_CYCLES = 250000,
  parameter int RETRIES     = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_mask,
  input  logic [DW-1:0] tgt_value,
  output logic          done,
  output logic          ok,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata
);
  localparam int RW = $clog2(RETRIES + 1);

  poll_st_e      st;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] val_q;
  logic [RW-1:0] left_q;
  logic          kick_q;
  logic          expired;
  logic          match;

  lrd_interval_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .kick    (kick_q),
    .expired (expired)
  );

  assign match = ((rsp_rdata & mask_q) == val_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= P_IDLE;
      mask_q    <= '0;
      val_q     <= '0;
      left_q    <= '0;
      kick_q    <= 1'b0;
      done      <= 1'b0;
      ok        <= 1'b0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      done   <= 1'b0;
      kick_q <= 1'b0;
      unique case (st)
        P_IDLE: if (start) begin
          mask_q    <= tgt_mask;
          val_q     <= tgt_value & tgt_mask;
          req_addr  <= tgt_addr;
          req_write <= 1'b0;
          req_valid <= 1'b1;
          st        <= P_RD;
        end
        P_RD: if (req_ready) begin
          req_valid <= 1'b0;
          st        <= P_RD_WAIT;
        end
        P_RD_WAIT: if (rsp_valid) begin
          req_wdata <= (rsp_rdata & ~mask_q) | val_q;
          req_write <= 1'b1;
          req_valid <= 1'b1;
          st        <= P_WR;
        end
        P_WR: if (req_ready) begin
          req_valid <= 1'b0;
          req_write <= 1'b0;
          left_q    <= RW'(RETRIES);
          kick_q    <= 1'b1;
          st        <= P_WAIT;
        end
        P_WAIT: if (expired) begin
          req_valid <= 1'b1;
          st        <= P_POLL;
        end
        P_POLL: if (req_ready) begin
          req_valid <= 1'b0;
          st        <= P_POLL_WAIT;
        end
        P_POLL_WAIT: if (rsp_valid) begin
          if (match) begin
            done <= 1'b1;
            ok   <= 1'b1;
            st   <= P_IDLE;
          end else if (left_q <= RW'(1)) begin
            done <= 1'b1;
            ok   <= 1'b0;
            st   <= P_IDLE;
          end else begin
            left_q <= left_q - RW'(1);
            kick_q <= 1'b1;
            st     <= P_WAIT;
          end
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
    left_q <= RW'(RETRIES)); // R4
  AST_DONE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rsp_valid)); // R3
  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (st == P_WAIT) |-> !req_valid); // R3
endmodule

// File: rtl/link_reset_detector.sv
module link_reset_detector
  import lrd_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int POLL_CYCLES = 250000,
  parameter int RETRIES     = 50
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  output logic [PRESENCE_W-1:0] codec_mask,
  output logic                  no_codec,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic                  req_write,
  output logic [AW-1:0]         req_addr,
  output logic [DW-1:0]         req_wdata,
  input  logic                  rsp_valid,
  input  logic [DW-1:0]         rsp_rdata
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(CTRL_OFFSET);
  localparam logic [AW-1:0] STS_ADDR  = AW'(STATUS_OFFSET);
  localparam logic [DW-1:0] RST_MASK  = DW'(1) << RESET_BIT;

  seq_st_e       st;
  logic          pl_start;
  logic          pl_bit;
  logic          pl_done;
  logic          pl_ok;
  logic          pl_valid;
  logic          pl_write;
  logic [AW-1:0] pl_addr;
  logic [DW-1:0] pl_wdata;
  logic          own_valid;
  logic          own_sel;
  logic          outstanding;

  lrd_rmw_poller #(
    .AW(AW), .DW(DW), .POLL_CYCLES(POLL_CYCLES), .RETRIES(RETRIES)
  ) u_poller (
    .clk       (clk),
    .rst       (rst),
    .start     (pl_start),
    .tgt_addr  (CTRL_ADDR),
    .tgt_mask  (RST_MASK),
    .tgt_value (pl_bit ? RST_MASK : '0),
    .done      (pl_done),
    .ok        (pl_ok),
    .req_valid (pl_valid),
    .req_write (pl_write),
    .req_addr  (pl_addr),
    .req_wdata (pl_wdata),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign own_sel   = (st == S_STS) || (st == S_STS_WAIT);
  assign req_valid = own_sel ? own_valid : pl_valid;
  assign req_write = own_sel ? 1'b0      : pl_write;
  assign req_addr  = own_sel ? STS_ADDR  : pl_addr;
  assign req_wdata = own_sel ? '0        : pl_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      codec_mask <= '0;
      no_codec   <= 1'b0;
      pl_start   <= 1'b0;
      pl_bit     <= 1'b0;
      own_valid  <= 1'b0;
    end else begin
      done     <= 1'b0;
      pl_start <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          busy       <= 1'b1;
          codec_mask <= '0;
          no_codec   <= 1'b0;
          pl_bit     <= 1'b0;
          pl_start   <= 1'b1;
          st         <= S_ENTER;
        end
        S_ENTER: if (pl_done) begin
          pl_bit   <= pl_ok;
          pl_start <= 1'b1;
          st       <= pl_ok ? S_EXIT : S_CLEAN;
        end
        S_EXIT: if (pl_done) begin
          if (pl_ok) begin
            own_valid <= 1'b1;
            st        <= S_STS;
          end else begin
            pl_bit   <= 1'b0;
            pl_start <= 1'b1;
            st       <= S_CLEAN;
          end
        end
        S_STS: if (req_ready) begin
          own_valid <= 1'b0;
          st        <= S_STS_WAIT;
        end
        S_STS_WAIT: if (rsp_valid) begin
          if (rsp_rdata[PRESENCE_W-1:0] != '0) begin
            codec_mask <= rsp_rdata[PRESENCE_W-1:0];
            done       <= 1'b1;
            busy       <= 1'b0;
            st         <= S_IDLE;
          end else begin
            pl_bit   <= 1'b0;
            pl_start <= 1'b1;
            st       <= S_CLEAN;
          end
        end
        S_CLEAN: if (pl_done) begin
          codec_mask <= '0;
          no_codec   <= 1'b1;
          done       <= 1'b1;
          busy       <= 1'b0;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) outstanding <= 1'b0;
    else if (req_valid && req_ready && !req_write) outstanding <= 1'b1;
    else if (rsp_valid) outstanding <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
      $stable(req_write) && $stable(req_wdata))); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    outstanding |-> !req_valid); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid); // R1
  AST_FAIL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (done && no_codec) |-> (codec_mask == '0)); // R7
  AST_OK_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    (done && !no_codec) |-> (codec_mask != '0)); // R6
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(codec_mask)); // R9
endmodule

// File: tb/link_reset_detector_bench.sv
`timescale 1ns/1ps
module link_reset_detector_bench;
  localparam int POLL = 8;
  localparam int RET  = 50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy, done, no_codec;
  logic [3:0]  codec_mask;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  link_reset_detector #(.AW(16), .DW(32), .POLL_CYCLES(POLL), .RETRIES(RET))
  u_link_reset_detector (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .codec_mask(codec_mask), .no_codec(no_codec), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // register model configuration, written by the stimulus only
  logic [31:0] cfg_ctrl, cfg_sts;
  int          cfg_lag;
  logic        cfg_stuck, cfg_stall, cfg_load = 1'b0;

  // register model state, written by the model only
  logic [31:0] ctrl_act, sts_val;
  logic        vis0, await_first;
  logic [7:0]  lf;
  int cyc, wr_cyc, pend, wr8, rd8, nw, gap_bad;
  logic [31:0] wlog [0:7];

  always @(posedge clk) begin
    cyc       <= cyc + 1;
    rsp_valid <= 1'b0;
    lf        <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    req_ready <= cfg_stall ? (lf[0] | lf[2]) : 1'b1;
    if (cfg_load) begin
      ctrl_act <= cfg_ctrl; sts_val <= cfg_sts; vis0 <= cfg_ctrl[0];
      pend <= 0; wr8 <= 0; rd8 <= 0; nw <= 0; gap_bad <= 0; await_first <= 1'b0;
    end else if (req_valid && req_ready) begin
      if (req_write) begin
        if (req_addr == 16'h0008) begin
          ctrl_act <= req_wdata; pend <= cfg_lag; wr_cyc <= cyc;
          await_first <= 1'b1; wr8 <= wr8 + 1; nw <= nw + 1;
          if (nw < 8) wlog[nw] <= req_wdata;
        end
      end else begin
        rsp_valid <= 1'b1;
        if (req_addr == 16'h0008) begin
          rd8 <= rd8 + 1;
          if (await_first) begin
            if (cyc - wr_cyc < POLL) gap_bad <= gap_bad + 1;
            await_first <= 1'b0;
          end
          if (cfg_stuck) rsp_rdata <= {ctrl_act[31:1], 1'b0};
          else if (pend > 0) begin
            pend <= pend - 1; rsp_rdata <= {ctrl_act[31:1], vis0};
          end else begin
            vis0 <= ctrl_act[0]; rsp_rdata <= ctrl_act;
          end
        end else if (req_addr == 16'h000E) rsp_rdata <= sts_val;
        else rsp_rdata <= 32'h0;
      end
    end
  end

  initial begin
    cyc = 0; lf = 8'h5A; req_ready = 1'b1; rsp_valid = 1'b0; rsp_rdata = '0;
    cfg_ctrl = 0; cfg_sts = 0; cfg_lag = 0; cfg_stuck = 0; cfg_stall = 0;
  end

  task automatic check_eq(input string req, input string what,
                          input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { logic [3:0] m; logic e; } exp_t;
  exp_t sb_q[$];
  int   dones = 0;

  always @(negedge clk) begin
    if (!rst && done) begin
      dones++;
      if (sb_q.size() == 0) check_eq("R10", "unexpected done", 1, 0);
      else begin
        exp_t x;
        x = sb_q.pop_front();
        check_eq("R6/R7", "codec_mask at done", codec_mask, x.m);
        check_eq("R6/R7", "no_codec at done", no_codec, x.e);
      end
    end
  end

  task automatic setup(input logic [31:0] c, input logic [31:0] s,
                       input int lag, input logic stuck, input logic stall);
    @(negedge clk);
    cfg_ctrl = c; cfg_sts = s; cfg_lag = lag; cfg_stuck = stuck; cfg_stall = stall;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic run_case(input logic [3:0] m, input logic e, input bit extra_start);
    exp_t x;
    int n;
    x.m = m; x.e = e;
    sb_q.push_back(x);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check_eq("R1", "busy after start", busy, 1);
    if (extra_start) begin
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check_eq("R1", "busy low at done", busy, 0);
    @(negedge clk);
    check_eq("R9", "done single cycle", done, 0);
    check_eq("R9", "mask held after done", codec_mask, m);
    check_eq("R9", "flag held after done", no_codec, e);
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: state out of reset
    check_eq("R10", "busy", busy, 0);
    check_eq("R10", "done", done, 0);
    check_eq("R10", "codec_mask", codec_mask, 0);
    check_eq("R10", "no_codec", no_codec, 0);
    check_eq("R10", "req_valid", req_valid, 0);

    // R2 R5 R3: clean run, foreign bits preserved, one readback per step
    setup(32'hA5A5_5A5B, 32'h0000_0005, 0, 1'b0, 1'b0);
    run_case(4'h5, 1'b0, 1'b0);
    check_eq("R2", "enter write merges", wlog[0], 32'hA5A5_5A5A);
    check_eq("R5", "exit write sets bit0", wlog[1], 32'hA5A5_5A5B);
    check_eq("R5", "write count", wr8, 2);
    check_eq("R3", "control reads", rd8, 4);
    check_eq("R3", "readback waited interval", gap_bad, 0);

    // R6: high status bits are ignored
    setup(32'h0000_0001, 32'hFFFF_FFF3, 0, 1'b0, 1'b0);
    run_case(4'h3, 1'b0, 1'b0);

    // R4 R8: bit lags two readbacks, bus stalls
    setup(32'h0000_0001, 32'h0000_0009, 2, 1'b0, 1'b1);
    run_case(4'h9, 1'b0, 1'b0);
    check_eq("R4", "lagging readback count", rd8, 8);
    check_eq("R8", "writes under stall", wr8, 2);
    check_eq("R8", "final control under stall", ctrl_act, 32'h0000_0001);
    check_eq("R3", "lag interval", gap_bad, 0);

    // R4 R7: reset bit never rises, timeout then clean-up
    setup(32'h0000_0010, 32'h0000_0005, 0, 1'b1, 1'b0);
    run_case(4'h0, 1'b1, 1'b0);
    check_eq("R4", "timeout readbacks", rd8, 55);
    check_eq("R7", "clean-up write issued", wr8, 3);
    check_eq("R7", "clean-up clears bit0", wlog[2][0], 0);

    // R7: empty presence field
    setup(32'hFFFF_FFFE, 32'h0000_00F0, 0, 1'b0, 1'b0);
    run_case(4'h0, 1'b1, 1'b0);
    check_eq("R7", "empty field clean-up writes", wr8, 3);
    check_eq("R7", "link left in reset", ctrl_act, 32'hFFFF_FFFE);

    // R1: second start while busy is ignored
    setup(32'h0000_0001, 32'h0000_0002, 0, 1'b0, 1'b0);
    d0 = dones;
    run_case(4'h2, 1'b0, 1'b1);
    repeat (200) @(negedge clk);
    check_eq("R1", "one done per run", dones - d0, 1);
    check_eq("R1", "no extra writes", wr8, 2);

    // R10: reset in the middle of a run
    setup(32'h0000_0001, 32'h0000_0004, 0, 1'b0, 1'b0);
    d0 = dones;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (25) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check_eq("R10", "busy after mid reset", busy, 0);
    check_eq("R10", "req_valid after mid reset", req_valid, 0);
    repeat (300) @(negedge clk);
    check_eq("R10", "no done after abort", dones - d0, 0);

    // R10: recovers to a normal run
    setup(32'h0000_0000, 32'h0000_0008, 0, 1'b0, 1'b0);
    run_case(4'h8, 1'b0, 1'b0);
    check_eq("R6", "scoreboard drained", sb_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule